// File: doc/BRIEF.md
# Digit-Serial Packed-Decimal Adder

This block adds two unsigned packed-decimal words of eight digits each, one digit per clock. A start pulse captures both operands, empties the result word and zeroes the running digit carry. On every following cycle the two lowest nibbles are added together with the running carry. A trial subtraction of ten then decides between the corrected digit with a carry and the plain digit without one. The two operand words and the result word then each rotate right by one nibble, so the next digit sits in the lowest position.

After eight digit steps the packed sum and the final decimal carry are on the outputs and a one-cycle done pulse marks them as valid. They stay unchanged until the next accepted start. The operands are assumed to hold valid decimal digits.

Top module: `bcd_serial_adder`

## Requirements
- R1: After reset, busy_o, done_o, carry_o and sum_o are all zero.
- R2: A start_i sampled high while busy_o is low is accepted. busy_o is high from the next cycle for exactly NDIG (8) cycles.
- R3: done_o is high for exactly one cycle, in the cycle after the last busy cycle (NDIG+1 cycles after the start edge). busy_o is low while done_o is high.
- R4: Digit i of each word sits in bits [4i+3:4i], and digit 0 is the least significant. When done_o is high, each digit of sum_o is the decimal sum of the matching operand digits plus the carry from the digit below.
- R5: A digit sum of ten or more stores the sum minus ten and passes a carry of one to the next digit. A digit sum below ten stores the sum and passes zero.
- R6: carry_o is one when done_o is high exactly when the decimal total is 10^8 or more. In that case sum_o holds the total minus 10^8.
- R7: A start_i pulse while busy_o is high is ignored. The result and the timing belong to the operands captured at the accepted start.
- R8: While no new start is accepted, sum_o and carry_o hold their values from the done cycle.
- R9: A start_i sampled high in the done cycle is accepted, so additions can follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an addition |
| opa_i | input | 32 | First packed-decimal operand |
| opb_i | input | 32 | Second packed-decimal operand |
| sum_o | output | 32 | Packed-decimal sum |
| carry_o | output | 1 | Decimal carry out of the top digit |
| busy_o | output | 1 | Digit steps in progress |
| done_o | output | 1 | One-cycle pulse when the sum is valid |

## Verification
The done pulse of one addition and the acceptance of the next start can fall on the same clock edge. In that cycle the finished sum must be seen intact while the operand and result registers reload. The bench provokes this by holding start_i high across the whole of an addition with new operands waiting. The first request is taken and the repeats during the busy cycles are dropped. The one in the done cycle must start a second addition whose sum and timing the reference model predicts on its own.

// File: rtl/bcd_ser_pkg.sv
package bcd_ser_pkg;

  localparam int unsigned NIB_W    = 4;
  localparam int unsigned DEC_BASE = 10;

  typedef struct packed {
    logic             carry;
    logic [NIB_W-1:0] digit;
  } dig_res_t;

  // One decimal digit step: binary add, then trial subtraction of the base.
  function automatic dig_res_t dec_digit_add(input logic [NIB_W-1:0] x,
                                             input logic [NIB_W-1:0] y,
                                             input logic             cin);
    logic [NIB_W:0]   raw;
    logic [NIB_W+1:0] trial;
    dig_res_t         r;
    raw   = {1'b0, x} + {1'b0, y} + {{NIB_W{1'b0}}, cin};
    trial = {1'b0, raw} - (NIB_W+2)'(DEC_BASE);
    if (!trial[NIB_W+1]) begin
      r.carry = 1'b1;
      r.digit = trial[NIB_W-1:0];
    end else begin
      r.carry = 1'b0;
      r.digit = raw[NIB_W-1:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_ser_pkg::*;
(
  input  logic [NIB_W-1:0] a_nib_i,
  input  logic [NIB_W-1:0] b_nib_i,
  input  logic             cin_i,
  output logic [NIB_W-1:0] digit_o,
  output logic             cout_o
);
  dig_res_t res;

  always_comb begin
    res     = dec_digit_add(a_nib_i, b_nib_i, cin_i);
    digit_o = res.digit;
    cout_o  = res.carry;
  end
endmodule

// File: rtl/bcd_nib_rotator.sv
module bcd_nib_rotator
  import bcd_ser_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [W-1:0]     load_val_i,
  input  logic             shift_i,
  input  logic [NIB_W-1:0] ins_nib_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] merged;

  // The inserted nibble is OR-ed into the low slot, then the word rotates right.
  always_comb begin
    merged = q_o;
    merged[NIB_W-1:0] = q_o[NIB_W-1:0] | ins_nib_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {merged[NIB_W-1:0], merged[W-1:NIB_W]};
  end
endmodule

// File: rtl/bcd_step_ctrl.sv
module bcd_step_ctrl #(
  parameter int unsigned NDIG = 8,
  localparam int unsigned CW  = $clog2(NDIG + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] left_q;

  assign accept_o = start_i && !busy_o;
  assign step_o   = busy_o;
  assign last_o   = busy_o && (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      left_q <= '0;
    end else begin
      done_o <= last_o;
      if (accept_o) begin
        busy_o <= 1'b1;
        left_q <= CW'(NDIG);
      end else if (busy_o) begin
        left_q <= left_q - CW'(1);
        if (last_o) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcd_serial_adder.sv
module bcd_serial_adder
  import bcd_ser_pkg::*;
#(
  parameter int unsigned NDIG = 8,
  localparam int unsigned W   = NDIG * NIB_W,
  localparam int unsigned NLANE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         busy_o,
  output logic         done_o
);
  // Named internal events, also observed by the checker.
  logic             start_accept;
  logic             step_fire;
  logic             last_step;
  logic [NIB_W-1:0] step_digit;
  logic             step_carry;
  logic             carry_q;

  logic [W-1:0]     lane_val [NLANE];
  logic [NIB_W-1:0] lane_ins [NLANE];
  logic [W-1:0]     lane_q   [NLANE];

  bcd_step_ctrl #(.NDIG(NDIG)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (start_accept),
    .step_o   (step_fire),
    .last_o   (last_step),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  // Lane 0: operand A, lane 1: operand B, lane 2: result (cleared at start).
  assign lane_val[0] = opa_i;
  assign lane_val[1] = opb_i;
  assign lane_val[2] = '0;
  assign lane_ins[0] = '0;
  assign lane_ins[1] = '0;
  assign lane_ins[2] = step_digit;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    bcd_nib_rotator #(.W(W)) rot_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start_accept),
      .load_val_i (lane_val[g]),
      .shift_i    (step_fire),
      .ins_nib_i  (lane_ins[g]),
      .q_o        (lane_q[g])
    );
  end

  bcd_digit_stage dig_i (
    .a_nib_i (lane_q[0][NIB_W-1:0]),
    .b_nib_i (lane_q[1][NIB_W-1:0]),
    .cin_i   (carry_q),
    .digit_o (step_digit),
    .cout_o  (step_carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            carry_q <= 1'b0;
    else if (start_accept) carry_q <= 1'b0;
    else if (step_fire)    carry_q <= step_carry;
  end

  assign sum_o   = lane_q[2];
  assign carry_o = carry_q;
endmodule

// File: rtl/bcd_serial_adder_chk.sv
module bcd_serial_adder_chk #(
  parameter int unsigned SUM_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             carry_o,
  input logic [SUM_W-1:0] sum_o,
  input logic             step_fire,
  input logic             last_step,
  input logic [3:0]       step_digit
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_digit_decimal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> (step_digit <= 4'd9));

  p_busy_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_step) |=> busy_o);

  p_sum_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(sum_o) && $stable(carry_o)));
endmodule

bind bcd_serial_adder bcd_serial_adder_chk #(.SUM_W(NDIG*4)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .carry_o    (carry_o),
  .sum_o      (sum_o),
  .step_fire  (step_fire),
  .last_step  (last_step),
  .step_digit (step_digit)
);

// File: tb/bcd_serial_adder_tb_top.sv
module bcd_serial_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 8;
  localparam int WDOG = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic [31:0] sum_o;
  logic        carry_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R4";

  // Reference model state
  bit          m_busy = 0, m_done = 0, m_hold = 0;
  int          m_left = 0;
  logic [31:0] m_sum = '0;
  bit          m_carry = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_serial_adder dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opa_i(opa_i), .opb_i(opb_i),
    .sum_o(sum_o), .carry_o(carry_o), .busy_o(busy_o), .done_o(done_o));

  function automatic longint to_dec(input logic [31:0] w);
    longint v = 0;
    for (int i = NDIG - 1; i >= 0; i--) v = v * 10 + longint'(w[i*4 +: 4]);
    return v;
  endfunction

  function automatic logic [31:0] to_bcd(input longint v);
    logic [31:0] w = '0;
    for (int i = 0; i < NDIG; i++) begin
      w[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return w;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_hold = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; m_hold = 1; end
      end else if (start_i) begin
        longint tot;
        tot = to_dec(opa_i) + to_dec(opb_i);
        m_carry = (tot >= 100000000);
        m_sum = to_bcd(tot % 100000000);
        m_busy = 1; m_left = NDIG; m_hold = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 busy", 32'(busy_o), 32'(m_busy));
      chk("R3 done", 32'(done_o), 32'(m_done));
      if (m_done) begin
        chk({cur_tag, " sum"}, sum_o, m_sum);
        chk("R6 carry", 32'(carry_o), 32'(m_carry));
      end else if (m_hold) begin
        chk("R8 held sum", sum_o, m_sum);
        chk("R8 held carry", 32'(carry_o), 32'(m_carry));
      end
    end
  end

  task automatic run_add(input string tag, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cur_tag = tag;
    opa_i = a; opb_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 sum", sum_o, 32'h0);
    chk("R1 carry", 32'(carry_o), 32'h0);
    chk("R1 busy", 32'(busy_o), 32'h0);
    chk("R1 done", 32'(done_o), 32'h0);

    run_add("R4", 32'h12345678, 32'h87654321);
    run_add("R4", 32'h00000000, 32'h00000000);
    run_add("R5", 32'h00000009, 32'h00000001);
    run_add("R5", 32'h05050505, 32'h05050505);
    run_add("R5", 32'h09999999, 32'h00000001);
    run_add("R6", 32'h99999999, 32'h00000001);
    run_add("R6", 32'h50000000, 32'h50000000);
    run_add("R6", 32'h99999999, 32'h99999999);

    // R7: start pulses with other operands during busy are ignored
    @(negedge clk);
    cur_tag = "R7";
    opa_i = 32'h11111111; opb_i = 32'h22222222; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    opa_i = 32'h99999999; opb_i = 32'h88888888; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);

    // R8: idle hold
    repeat (10) @(negedge clk);

    // R9: start held high across done, new operands waiting
    cur_tag = "R9";
    opa_i = 32'h00004567; opb_i = 32'h00005678; start_i = 1'b1;
    @(negedge clk);
    opa_i = 32'h31415926; opb_i = 32'h27182818;
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk("R9 restarted busy", 32'(busy_o), 32'h1);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > WDOG);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule